// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the serial-slave command engine of a 4096-byte EEPROM that talks SPI mode 0 (or mode 3). The chip select, serial clock and serial data input are sampled with the system clock. The engine collects an 8-bit opcode and a 16-bit address, most significant bit first. It then either streams array bytes out on the serial data output or gathers data bytes into a 32-byte page latch. The array itself is a small behavioural byte memory held inside the block.

When the host ends a write sequence on a clean byte boundary and the external write-enable flag is set, the engine pulses a write-start strobe to the status unit. It then holds a busy flag for a programmable number of system clocks, which stands in for the internal programming time. The latched bytes reach the array at the end of that interval. While busy, new array reads and new writes are refused, and chip select activity does not cut the cycle short.

Top module: `eeprom_spi_engine`

## Requirements
- R1: Serial input bits are taken on rising edges of `sck`, most significant bit first. `so` changes only after falling edges of `sck`, so each output bit is stable before the next rising edge. A sequence starts with the first `cs_n` high-to-low transition seen after reset. If `cs_n` is already low when reset ends, that sequence is ignored.
- R2: Opcode 8'h03 followed by a 16-bit address, whose upper four bits are ignored, starts a read. The byte at the address appears on `so` MSB first, beginning after the falling edge that follows the last address bit.
- R3: During a read, the address advances by one after each byte is sent, and it wraps from 12'hFFF to 12'h000 for as long as `cs_n` stays low.
- R4: Opcode 8'h02 followed by a 16-bit address starts a write. Data bytes fill a page latch starting at address bits [4:0], with bits [11:5] held fixed. Bits [4:0] wrap from 31 to 0, so a later byte overwrites an earlier byte at the same offset.
- R5: A write commits only when all three of these hold: `cs_n` rises with zero bits of a following byte received, at least one complete data byte was received, and `wel` is 1. Otherwise the array is unchanged and `wr_start` stays 0.
- R6: A commit raises `wr_start` for exactly one clock. On the next clock `busy` rises and stays high for exactly WR_CYCLES clocks, whatever `cs_n` does meanwhile. The array is updated when `busy` falls.
- R7: `so_oe` is 0 after reset, whenever `cs_n` is high, and outside the read data phase.
- R8: A read opcode received while `busy` is high is refused: `so_oe` stays 0 for the whole sequence.
- R9: A write opcode received while `busy` is high is ignored: no further `wr_start` occurs and the array is unchanged.
- R10: A commit writes only the page offsets that were loaded in that sequence. Every other byte of the page keeps its previous value.
- R11: Any opcode other than 8'h03 and 8'h02 is ignored until `cs_n` rises. `so_oe` stays 0 and `wr_start` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| wel | input | 1 | Write-enable flag from the status unit |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| wr_start | output | 1 | One-clock pulse when an internal write cycle begins |
| busy | output | 1 | High while the internal write cycle runs |

## Verification
Each pin passes a two-stage synchronizer, and its edge is detected one clock later. A new `so` bit is therefore due three system clocks after the falling `sck` edge. The bench holds each `sck` level for six clocks and samples `so` just before it raises `sck`. A commit shows on `wr_start` three clocks after `cs_n` rises, and `busy` follows on the next clock. The bench therefore waits twelve clocks before it probes, and it counts the length of every `busy` run exactly against WR_CYCLES. A per-clock reference model, built from a byte array and a page-wrap rule, supplies every expected read byte. It also requires `so_oe` to be 0 on every clock after `cs_n` has been high for four clocks.

// File: rtl/eeprom_spi_pkg.sv
`timescale 1ns/1ps
package eeprom_spi_pkg;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPCODE, PH_ADDR, PH_RDATA, PH_WDATA, PH_SKIP
    } phase_t;

    // Events seen after synchronizing the serial pins
    typedef struct packed {
        logic cs_start;
        logic cs_end;
        logic sck_rise;
        logic sck_fall;
        logic sdi;
    } spi_evt_t;

    function automatic logic is_known_op(input logic [7:0] op);
        return (op == OPC_READ) || (op == OPC_WRITE);
    endfunction
endpackage

// File: rtl/spi_pin_sampler.sv
`timescale 1ns/1ps
module spi_pin_sampler
    import eeprom_spi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     si,
    output spi_evt_t evt
);
    logic [2:0] act_q;
    logic [2:0] sck_q;
    logic [1:0] si_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 3'b111;   // a select already low at reset is not a start
            sck_q <= 3'b000;
            si_q  <= 2'b00;
        end else begin
            act_q <= {act_q[1:0], ~cs_n};
            sck_q <= {sck_q[1:0], sck};
            si_q  <= {si_q[0], si};
        end
    end

    always_comb begin
        evt.cs_start = act_q[1] & ~act_q[2];
        evt.cs_end   = ~act_q[1] & act_q[2];
        evt.sck_rise = sck_q[1] & ~sck_q[2];
        evt.sck_fall = ~sck_q[1] & sck_q[2];
        evt.sdi      = si_q[1];
    end
endmodule

// File: rtl/eeprom_page_latch.sv
`timescale 1ns/1ps
module eeprom_page_latch #(
    parameter int PAGE_BYTES = 32,
    localparam int PTR_W = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    open_pg,
    input  logic [PTR_W-1:0]        ptr_init,
    input  logic                    push,
    input  logic [7:0]              din,
    output logic [PAGE_BYTES*8-1:0] pdata,
    output logic [PAGE_BYTES-1:0]   pmask
);
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= '0;
        else if (open_pg) ptr_q <= ptr_init;
        else if (push)    ptr_q <= ptr_q + 1'b1;   // wraps inside the page
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        logic       vld_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
                vld_q  <= 1'b0;
            end else if (open_pg) begin
                vld_q  <= 1'b0;
            end else if (push && ptr_q == PTR_W'(g)) begin
                lane_q <= din;
                vld_q  <= 1'b1;
            end
        end
        assign pdata[g*8 +: 8] = lane_q;
        assign pmask[g]        = vld_q;
    end
endmodule

// File: rtl/eeprom_store.sv
`timescale 1ns/1ps
module eeprom_store #(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 625000,
    localparam int PTR_W  = $clog2(PAGE_BYTES),
    localparam int BASE_W = ADDR_W - PTR_W,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int TMR_W  = $clog2(WR_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [7:0]              rdata,
    input  logic                    start,
    input  logic [BASE_W-1:0]       page_base,
    input  logic [PAGE_BYTES*8-1:0] pdata,
    input  logic [PAGE_BYTES-1:0]   pmask,
    output logic                    busy
);
    logic [7:0]        mem [DEPTH];
    logic [BASE_W-1:0] base_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              busy_q;
    logic              finish;

    assign finish = busy_q && (tmr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            base_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            tmr_q  <= TMR_W'(WR_CYCLES - 1);
            base_q <= page_base;
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            tmr_q  <= tmr_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (finish) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pmask[i]) mem[{base_q, PTR_W'(i)}] <= pdata[i*8 +: 8];
            end
        end
    end

    assign rdata = mem[raddr];
    assign busy  = busy_q;
endmodule

// File: rtl/eeprom_spi_engine.sv
`timescale 1ns/1ps
module eeprom_spi_engine
    import eeprom_spi_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wel,
    output logic so,
    output logic so_oe,
    output logic wr_start,
    output logic busy
);
    localparam int PTR_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - PTR_W;

    spi_evt_t             evt;
    phase_t               phase_q;
    logic [2:0]           bitcnt_q;
    logic                 addr_hi_done_q;
    logic                 op_rd_q;
    logic                 have_byte_q;
    logic [14:0]          sh_q;
    logic [15:0]          nxt_bits;
    logic [ADDR_W-1:0]    addr_q;
    logic [7:0]           out_byte_q;
    logic [7:0]           cur_byte;
    logic [7:0]           rdata;
    logic                 so_q;
    logic                 start_q;
    logic                 byte_done;
    logic                 quiet;
    logic                 open_pg;
    logic                 push;
    logic [PAGE_BYTES*8-1:0] pdata;
    logic [PAGE_BYTES-1:0]   pmask;
    logic                 unused_addr_top;

    spi_pin_sampler u_pins (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .evt(evt)
    );

    assign nxt_bits        = {sh_q, evt.sdi};
    assign unused_addr_top = ^nxt_bits[15:ADDR_W];
    assign byte_done       = evt.sck_rise && (bitcnt_q == 3'd7);
    assign quiet           = !evt.cs_start && !evt.cs_end;
    assign open_pg         = quiet && phase_q == PH_ADDR && byte_done
                             && addr_hi_done_q && !op_rd_q;
    assign push            = quiet && phase_q == PH_WDATA && byte_done;
    assign cur_byte        = (bitcnt_q == 3'd0) ? rdata : out_byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q        <= PH_IDLE;
            bitcnt_q       <= '0;
            addr_hi_done_q <= 1'b0;
            op_rd_q        <= 1'b0;
            have_byte_q    <= 1'b0;
            sh_q           <= '0;
            addr_q         <= '0;
            out_byte_q     <= '0;
            so_q           <= 1'b0;
            start_q        <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (evt.cs_end) begin
                phase_q <= PH_IDLE;
                if (phase_q == PH_WDATA && bitcnt_q == 3'd0 && have_byte_q
                    && wel && !busy)
                    start_q <= 1'b1;
            end else if (evt.cs_start) begin
                phase_q        <= PH_OPCODE;
                bitcnt_q       <= '0;
                addr_hi_done_q <= 1'b0;
                have_byte_q    <= 1'b0;
            end else begin
                if (evt.sck_rise && phase_q != PH_IDLE) begin
                    sh_q     <= nxt_bits[14:0];
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
                unique case (phase_q)
                    PH_OPCODE: if (byte_done) begin
                        op_rd_q <= (nxt_bits[7:0] == OPC_READ);
                        phase_q <= (is_known_op(nxt_bits[7:0]) && !busy)
                                   ? PH_ADDR : PH_SKIP;
                    end
                    PH_ADDR: if (byte_done) begin
                        addr_hi_done_q <= 1'b1;
                        if (addr_hi_done_q) begin
                            addr_q  <= nxt_bits[ADDR_W-1:0];
                            phase_q <= op_rd_q ? PH_RDATA : PH_WDATA;
                        end
                    end
                    PH_RDATA: if (evt.sck_fall) begin
                        so_q <= cur_byte[3'd7 - bitcnt_q];
                        if (bitcnt_q == 3'd0) out_byte_q <= rdata;
                        if (bitcnt_q == 3'd7) addr_q <= addr_q + 1'b1;
                    end
                    PH_WDATA: if (byte_done) have_byte_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    eeprom_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk(clk), .rst(rst), .open_pg(open_pg),
        .ptr_init(nxt_bits[PTR_W-1:0]), .push(push), .din(nxt_bits[7:0]),
        .pdata(pdata), .pmask(pmask)
    );

    eeprom_store #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
    ) u_store (
        .clk(clk), .rst(rst), .raddr(addr_q), .rdata(rdata),
        .start(start_q), .page_base(addr_q[ADDR_W-1 -: BASE_W]),
        .pdata(pdata), .pmask(pmask), .busy(busy)
    );

    assign so       = so_q;
    assign so_oe    = (phase_q == PH_RDATA);
    assign wr_start = start_q;
endmodule

// File: rtl/eeprom_spi_engine_chk.sv
`timescale 1ns/1ps
module eeprom_spi_engine_chk #(
    parameter int WR_CYCLES = 625000
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic wel,
    input logic so_oe,
    input logic wr_start,
    input logic busy
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    p_hiz_deselected_r7: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    p_start_sets_busy_r6: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> busy);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == WR_CYCLES));

    p_no_read_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !so_oe);

    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> !busy);

    p_commit_needs_wel_r5: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> $past(wel));
endmodule

bind eeprom_spi_engine eeprom_spi_engine_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (.*);

// File: tb/eeprom_spi_engine_bench.sv
`timescale 1ns/1ps
module eeprom_spi_engine_bench;
    localparam int WRC = 1500;
    localparam int H   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, wel = 1'b0;
    logic so, so_oe, wr_start, busy;

    int n_cmp = 0, n_bad = 0;
    int n_starts = 0, run_len = 0, last_len = 0, cs_hi = 0;
    bit done = 1'b0;
    logic [7:0] mem_m [4096];
    logic [7:0] wbuf [64];

    always #4 clk = ~clk;

    eeprom_spi_engine #(.WR_CYCLES(WRC)) u_eeprom_spi_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wel(wel),
        .so(so), .so_oe(so_oe), .wr_start(wr_start), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock observation: pulses, busy runs, deselected output enable (R7)
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_start) n_starts++;
            if (busy) run_len++;
            else if (run_len != 0) begin last_len = run_len; run_len = 0; end
            cs_hi = cs_n ? cs_hi + 1 : 0;
            if (cs_hi >= 4) chk(so_oe == 1'b0, "R7 so_oe while deselected", so_oe, 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input logic [7:0] b, input int nb, input bit want_oe,
                        input bit check_oe, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            si = b[i];
            tick(H);
            r[i] = so;
            if (check_oe) chk(so_oe == want_oe, "R8/R11 so_oe level", so_oe, want_oe);
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic desel();
        tick(H);
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    // write sequence; bytes come from wbuf; model updated when commit expected
    task automatic wr_seq(input logic [15:0] a, input int n, input bit w, input bit expect_commit);
        logic [7:0] r;
        wel = w;
        sel();
        bits(8'h02, 8, 0, 0, r);
        bits(a[15:8], 8, 0, 0, r);
        bits(a[7:0], 8, 0, 0, r);
        for (int k = 0; k < n; k++) bits(wbuf[k], 8, 0, 0, r);
        desel();
        if (expect_commit)
            for (int k = 0; k < n; k++)
                mem_m[{a[11:5], 5'(a[4:0] + 5'(k))}] = wbuf[k];
    endtask

    task automatic rd_seq(input logic [15:0] a, input int n, input string tag);
        logic [7:0] r;
        sel();
        bits(8'h03, 8, 0, 0, r);
        bits(a[15:8], 8, 0, 0, r);
        bits(a[7:0], 8, 0, 0, r);
        for (int k = 0; k < n; k++) begin
            logic [11:0] ma;
            ma = 12'(a[11:0] + 12'(k));
            bits(8'h00, 8, 1, 1, r);
            chk(r === mem_m[ma], tag, r, mem_m[ma]);
        end
        desel();
    endtask

    task automatic wait_cycle_end(input int starts_before, input string tag);
        tick(WRC + 40);
        chk(n_starts == starts_before + 1, {tag, " R6 one wr_start"}, n_starts, starts_before + 1);
        chk(last_len == WRC, {tag, " R6 busy length"}, last_len, WRC);
    endtask

    initial begin
        logic [7:0] r;
        int s0;
        tick(5);
        // reset state (R7)
        chk(so_oe == 1'b0, "R7 reset so_oe", so_oe, 0);
        chk(busy == 1'b0, "R6 reset busy", busy, 0);
        chk(wr_start == 1'b0, "R6 reset wr_start", wr_start, 0);
        rst = 1'b0;
        tick(3);
        // select low at power-up: sequence ignored (R1, R7)
        bits(8'h03, 8, 0, 1, r);
        bits(8'h00, 8, 0, 1, r);
        bits(8'h00, 8, 0, 1, r);
        bits(8'h00, 8, 0, 1, r);
        desel();
        chk(n_starts == 0, "R1 no start before first select", n_starts, 0);

        // full page at 0x120, then partial overwrite (R4, R6)
        for (int k = 0; k < 32; k++) wbuf[k] = 8'h40 + 8'(k);
        s0 = n_starts;
        wr_seq(16'h0120, 32, 1, 1);
        wait_cycle_end(s0, "full page");
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
        s0 = n_starts;
        wr_seq(16'h0123, 4, 1, 1);
        // read while busy is refused; select activity does not abort (R8)
        chk(busy == 1'b1, "R6 busy after commit", busy, 1);
        sel();
        bits(8'h03, 8, 0, 1, r);
        bits(8'h01, 8, 0, 1, r);
        bits(8'h20, 8, 0, 1, r);
        bits(8'h00, 8, 0, 1, r);
        desel();
        wait_cycle_end(s0, "partial");
        rd_seq(16'h0120, 8, "R10 R2 R1 partial page read");
        rd_seq(16'hF123, 2, "R2 upper address bits ignored");

        // page wrap inside the top page, then whole-array read wrap
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
        s0 = n_starts;
        wr_seq(16'h0FFE, 4, 1, 1);
        wait_cycle_end(s0, "R4 wrap write");
        wbuf[0] = 8'hD0; wbuf[1] = 8'hD1;
        s0 = n_starts;
        wr_seq(16'h0000, 2, 1, 1);
        wait_cycle_end(s0, "low page");
        rd_seq(16'h0FFE, 4, "R3 read wraps FFF to 000");
        rd_seq(16'h0FE0, 2, "R4 page wrap landing");

        // 33 bytes overwrite the first offset of the page (R4)
        for (int k = 0; k < 33; k++) wbuf[k] = 8'h10 + 8'(k);
        s0 = n_starts;
        wr_seq(16'h0045, 33, 1, 1);
        wait_cycle_end(s0, "R4 overrun");
        rd_seq(16'h0040, 32, "R4 overrun contents");

        // no commit: wel low, cs mid-byte, no data byte (R5)
        wbuf[0] = 8'h55;
        s0 = n_starts;
        wr_seq(16'h0123, 1, 0, 0);
        tick(WRC + 40);
        chk(n_starts == s0, "R5 wel clear no start", n_starts, s0);
        wel = 1'b1;
        sel();
        bits(8'h02, 8, 0, 0, r);
        bits(8'h01, 8, 0, 0, r);
        bits(8'h23, 8, 0, 0, r);
        bits(8'h66, 8, 0, 0, r);
        bits(8'h77, 3, 0, 0, r);
        desel();
        tick(WRC + 40);
        chk(n_starts == s0, "R5 mid-byte rise no start", n_starts, s0);
        wr_seq(16'h0123, 0, 1, 0);
        tick(WRC + 40);
        chk(n_starts == s0, "R5 no data byte no start", n_starts, s0);
        rd_seq(16'h0123, 1, "R5 array unchanged");

        // write while busy is ignored (R9)
        wbuf[0] = 8'hE1;
        s0 = n_starts;
        wr_seq(16'h0050, 1, 1, 1);
        wbuf[0] = 8'hE2;
        wr_seq(16'h0050, 1, 1, 0);
        wait_cycle_end(s0, "R9 busy write");
        chk(n_starts == s0 + 1, "R9 no second start", n_starts, s0 + 1);
        rd_seq(16'h0050, 1, "R9 first data kept");

        // unknown opcode (R11)
        s0 = n_starts;
        sel();
        bits(8'h05, 8, 0, 1, r);
        bits(8'h00, 8, 0, 1, r);
        bits(8'h50, 8, 0, 1, r);
        desel();
        tick(20);
        chk(n_starts == s0, "R11 unknown opcode no start", n_starts, s0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule